// File: doc/BRIEF.md
# Configuration Space Index/Data Port Bridge

This block lets a CPU reach PCI configuration space through two registers. One is a 32-bit index register that holds the target configuration address and an enable flag in its top bit. The other is a data window: a CPU read or write of 1, 2 or 4 bytes there becomes one request on a simple configuration bus. That request carries the address, the byte count, the write data and a valid/ready handshake, and read data comes back with its own valid strobe.

The bridge applies the enable gate. Writes to a closed window are discarded. Reads from a closed window answer locally with all-ones of the access width. For enabled accesses the bridge merges the CPU's byte offset into the forwarded address, right-justifies and masks the data, and can optionally swap the bytes of halfword and word data for a big-endian host. Only one configuration request is in flight at a time. The CPU port holds its ready low until that request has finished.

Top module: `cfg_port_bridge`

## Requirements
- R1: The index register (selected with `cpu_req_sel`=0) is a full 32-bit read/write register that reads back what was written and resets to zero. A read of it answers with `cpu_rsp_valid` one cycle after acceptance.
- R2: A data-window write (`cpu_req_sel`=1) while bit 31 of the index register is 0 is discarded. No configuration request is raised and the CPU port stays ready.
- R3: A data-window read while bit 31 of the index register is 0 raises no configuration request. It answers one cycle after acceptance with 0x000000FF for a byte, 0x0000FFFF for a halfword or 0xFFFFFFFF for a word.
- R4: While bit 31 is 1, a data-window access raises `cfg_req_valid` in the cycle after acceptance. It holds the valid and every request field steady until `cfg_req_ready` is seen.
- R5: For byte and halfword writes, `cfg_req_addr` is the index register ORed with `cpu_req_lo` in bits 1:0.
- R6: For word writes, `cfg_req_addr` equals the index register, with `cpu_req_lo` ignored.
- R7: For reads of every width, word included, `cfg_req_addr` is the index register ORed with `cpu_req_lo`.
- R8: `cpu_req_size` 0, 1 and 2 (byte, halfword, word; 3 is treated as word) forward as `cfg_req_size` 1, 2 and 4.
- R9: Write data and returned read data are right-justified, and all bits above the access width are zero.
- R10: With `BIG_ENDIAN`=1, halfword and word write data is byte-reversed before forwarding, and returned read data is byte-reversed after masking. Byte accesses are never reversed. With `BIG_ENDIAN`=0 no reversal occurs.
- R11: From acceptance of a forwarded access, `cpu_req_ready` is low. For a write it stays low until the configuration handshake. For a read it stays low until the cycle after `cfg_rsp_valid`, which is also the cycle `cpu_rsp_valid` pulses with the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU access request |
| cpu_req_ready | output | 1 | Bridge can accept a CPU access |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_sel | input | 1 | 0 = index register, 1 = data window |
| cpu_req_lo | input | 2 | Low byte-offset bits of the CPU address |
| cpu_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_req_wdata | input | DATA_W | CPU write data, right-justified |
| cpu_rsp_valid | output | 1 | Read data strobe to the CPU |
| cpu_rsp_data | output | DATA_W | Read data to the CPU |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration bus accepts the request |
| cfg_req_we | output | 1 | Request is a write |
| cfg_req_addr | output | ADDR_W | Forwarded configuration address |
| cfg_req_size | output | 3 | Byte count: 1, 2 or 4 |
| cfg_req_wdata | output | DATA_W | Forwarded write data |
| cfg_rsp_valid | input | 1 | Configuration read data valid |
| cfg_rsp_data | input | DATA_W | Configuration read data, right-justified |

## Verification
Some properties are checked by the embedded assertions on every cycle: a held request keeps its fields while the bus stalls, no request leaves with the enable bit clear, the byte count is always one of the three legal values, the CPU port is never ready during a request, and a word write carries the index register's low bits untouched. Other behaviour is visible only in the directed scenarios. These cover the value of the merged address for each width and offset, the exact all-ones answers of a closed window, the masking of stray upper data bits, and the byte reversal. The reversal is checked by running a little-endian and a big-endian instance side by side on the same stimulus.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } cpu_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } brg_state_e;

   localparam int unsigned BUS_DW = 32;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [BUS_DW-1:0] size_mask(input logic [1:0] code);
      case (code)
         SZ_BYTE: size_mask = 32'h0000_00FF;
         SZ_HALF: size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [BUS_DW-1:0] swap_sized(input logic [BUS_DW-1:0] d,
                                                    input logic [1:0] code);
      case (code)
         SZ_BYTE: swap_sized = d;
         SZ_HALF: swap_sized = {16'h0000, d[7:0], d[15:8]};
         default: swap_sized = {d[7:0], d[15:8], d[23:16], d[31:24]};
      endcase
   endfunction

endpackage

// File: rtl/cfgb_index_reg.sv
module cfgb_index_reg #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned EN_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] value,
   output logic              enabled
);

   generate
      if (EN_BIT >= ADDR_W) begin : g_bad_en_bit
         $error("cfgb_index_reg: EN_BIT must lie inside ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (wr_en) begin
         idx_q <= wr_data;
      end
   end

   assign value   = idx_q;
   assign enabled = idx_q[EN_BIT];

   // R1
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(value));

endmodule

// File: rtl/cfgb_req_former.sv
module cfgb_req_former
   import cfgb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic [ADDR_W-1:0] idx_value,
   input  logic              we,
   input  logic [1:0]        lo,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [2:0]        fwd_size,
   output logic [DATA_W-1:0] fwd_wdata
);

   localparam int unsigned LO_W = 2;

   logic              merge_lo;
   logic [DATA_W-1:0] masked;

   always_comb begin
      merge_lo  = !(we && (size_bytes(size) == 3'd4));
      fwd_addr  = idx_value;
      if (merge_lo) begin
         fwd_addr[LO_W-1:0] = idx_value[LO_W-1:0] | lo;
      end
      fwd_size  = size_bytes(size);
      masked    = wdata & size_mask(size);
   end

   generate
      if (BIG_ENDIAN) begin : g_swap
         assign fwd_wdata = swap_sized(masked, size);
      end else begin : g_plain
         assign fwd_wdata = masked;
      end
   endgenerate

endmodule

// File: rtl/cfgb_rsp_former.sv
module cfgb_rsp_former
   import cfgb_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] shaped,
   output logic [DATA_W-1:0] closed_value
);

   logic [DATA_W-1:0] masked;

   assign masked       = raw & size_mask(size);
   assign closed_value = size_mask(size);

   generate
      if (BIG_ENDIAN) begin : g_swap
         assign shaped = swap_sized(masked, size);
      end else begin : g_plain
         assign shaped = masked;
      end
   endgenerate

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cfgb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned EN_BIT     = 31,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic              cpu_req_we,
   input  logic              cpu_req_sel,
   input  logic [1:0]        cpu_req_lo,
   input  logic [1:0]        cpu_req_size,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_data,
   output logic              cfg_req_valid,
   input  logic              cfg_req_ready,
   output logic              cfg_req_we,
   output logic [ADDR_W-1:0] cfg_req_addr,
   output logic [2:0]        cfg_req_size,
   output logic [DATA_W-1:0] cfg_req_wdata,
   input  logic              cfg_rsp_valid,
   input  logic [DATA_W-1:0] cfg_rsp_data
);

   localparam int unsigned SIZE_W = 2;

   generate
      if (DATA_W != BUS_DW) begin : g_bad_data_w
         $error("cfg_port_bridge: DATA_W must be 32");
      end
      if (ADDR_W != DATA_W) begin : g_bad_addr_w
         $error("cfg_port_bridge: ADDR_W must equal DATA_W");
      end
   endgenerate

   brg_state_e          state_q;
   logic                accept;
   logic                idx_wr;
   logic [ADDR_W-1:0]   idx_value;
   logic                idx_enabled;

   logic [ADDR_W-1:0]   fwd_addr;
   logic [2:0]          fwd_size;
   logic [DATA_W-1:0]   fwd_wdata;

   logic                req_we_q;
   logic [ADDR_W-1:0]   req_addr_q;
   logic [2:0]          req_size_q;
   logic [DATA_W-1:0]   req_wdata_q;
   logic [SIZE_W-1:0]   rd_code_q;

   logic [DATA_W-1:0]   rsp_shaped;
   logic [DATA_W-1:0]   closed_value;
   logic                rsp_valid_q;
   logic [DATA_W-1:0]   rsp_data_q;

   assign accept = cpu_req_valid && (state_q == ST_IDLE);
   assign idx_wr = accept && !cpu_req_sel && cpu_req_we;

   cfgb_index_reg #(
      .ADDR_W (ADDR_W),
      .EN_BIT (EN_BIT)
   ) i_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (idx_wr),
      .wr_data (cpu_req_wdata[ADDR_W-1:0]),
      .value   (idx_value),
      .enabled (idx_enabled)
   );

   cfgb_req_former #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) i_req_former (
      .idx_value (idx_value),
      .we        (cpu_req_we),
      .lo        (cpu_req_lo),
      .size      (cpu_req_size),
      .wdata     (cpu_req_wdata),
      .fwd_addr  (fwd_addr),
      .fwd_size  (fwd_size),
      .fwd_wdata (fwd_wdata)
   );

   // Closed-window answer uses the live CPU size; device data uses the stored one.
   logic [1:0] shape_code;
   assign shape_code = (state_q == ST_IDLE) ? cpu_req_size : rd_code_q;

   cfgb_rsp_former #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) i_rsp_former (
      .raw          (cfg_rsp_data),
      .size         (shape_code),
      .shaped       (rsp_shaped),
      .closed_value (closed_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_we_q    <= 1'b0;
         req_addr_q  <= '0;
         req_size_q  <= 3'd0;
         req_wdata_q <= '0;
         rd_code_q   <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!cpu_req_sel) begin
                     if (!cpu_req_we) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= DATA_W'(idx_value);
                     end
                  end else if (!idx_enabled) begin
                     if (!cpu_req_we) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= closed_value;
                     end
                  end else begin
                     state_q     <= ST_ISSUE;
                     req_we_q    <= cpu_req_we;
                     req_addr_q  <= fwd_addr;
                     req_size_q  <= fwd_size;
                     req_wdata_q <= cpu_req_we ? fwd_wdata : '0;
                     rd_code_q   <= cpu_req_size;
                  end
               end
            end
            ST_ISSUE: begin
               if (cfg_req_ready) begin
                  state_q <= req_we_q ? ST_IDLE : ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (cfg_rsp_valid) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= rsp_shaped;
                  state_q     <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_req_ready = (state_q == ST_IDLE);
   assign cpu_rsp_valid = rsp_valid_q;
   assign cpu_rsp_data  = rsp_data_q;
   assign cfg_req_valid = (state_q == ST_ISSUE);
   assign cfg_req_we    = req_we_q;
   assign cfg_req_addr  = req_addr_q;
   assign cfg_req_size  = req_size_q;
   assign cfg_req_wdata = req_wdata_q;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_addr)
         && $stable(cfg_req_wdata) && $stable(cfg_req_size) && $stable(cfg_req_we));

   // R2
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid |-> cfg_req_addr[EN_BIT]);

   // R8
   req_size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid |-> ($countones(cfg_req_size) == 1));

   // R11
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid |-> !cpu_req_ready);

   // R6
   word_write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req_valid && cfg_req_we && (cfg_req_size == 3'd4)
         |-> (cfg_req_addr == idx_value));

endmodule

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0;
   logic        cpu_req_we = 1'b0;
   logic        cpu_req_sel = 1'b0;
   logic [1:0]  cpu_req_lo = 2'd0;
   logic [1:0]  cpu_req_size = 2'd0;
   logic [31:0] cpu_req_wdata = '0;
   logic        cfg_req_ready = 1'b0;
   logic        cfg_rsp_valid = 1'b0;
   logic [31:0] cfg_rsp_data = '0;

   logic        l_ready, l_rsp_valid, l_req_valid, l_req_we;
   logic [31:0] l_rsp_data, l_req_addr, l_req_wdata;
   logic [2:0]  l_req_size;
   logic        b_ready, b_rsp_valid, b_req_valid, b_req_we;
   logic [31:0] b_rsp_data, b_req_addr, b_req_wdata;
   logic [2:0]  b_req_size;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   cfg_port_bridge #(.BIG_ENDIAN(1'b0)) i_cfg_port_bridge (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(l_ready),
      .cpu_req_we(cpu_req_we), .cpu_req_sel(cpu_req_sel),
      .cpu_req_lo(cpu_req_lo), .cpu_req_size(cpu_req_size),
      .cpu_req_wdata(cpu_req_wdata),
      .cpu_rsp_valid(l_rsp_valid), .cpu_rsp_data(l_rsp_data),
      .cfg_req_valid(l_req_valid), .cfg_req_ready(cfg_req_ready),
      .cfg_req_we(l_req_we), .cfg_req_addr(l_req_addr),
      .cfg_req_size(l_req_size), .cfg_req_wdata(l_req_wdata),
      .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data));

   cfg_port_bridge #(.BIG_ENDIAN(1'b1)) i_cfg_port_bridge_be (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(b_ready),
      .cpu_req_we(cpu_req_we), .cpu_req_sel(cpu_req_sel),
      .cpu_req_lo(cpu_req_lo), .cpu_req_size(cpu_req_size),
      .cpu_req_wdata(cpu_req_wdata),
      .cpu_rsp_valid(b_rsp_valid), .cpu_rsp_data(b_rsp_data),
      .cfg_req_valid(b_req_valid), .cfg_req_ready(cfg_req_ready),
      .cfg_req_we(b_req_we), .cfg_req_addr(b_req_addr),
      .cfg_req_size(b_req_size), .cfg_req_wdata(b_req_wdata),
      .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Presents one CPU access; returns at the falling edge after acceptance.
   task automatic cpu_access(input logic sel, input logic we, input logic [1:0] lo,
                             input logic [1:0] size, input logic [31:0] wdata);
      @(negedge clk);
      cpu_req_valid = 1'b1;
      cpu_req_sel   = sel;
      cpu_req_we    = we;
      cpu_req_lo    = lo;
      cpu_req_size  = size;
      cpu_req_wdata = wdata;
      @(negedge clk);
      cpu_req_valid = 1'b0;
      cpu_req_wdata = 32'hFFFF_FFFF;
   endtask

   task automatic set_index(input logic [31:0] v);
      cpu_access(1'b0, 1'b1, 2'd0, 2'd2, v);
   endtask

   task automatic t_reset;
      chk("R1 reset ready", {31'd0, l_ready & b_ready}, 32'd1);
      chk("R1 reset no request", {31'd0, l_req_valid | b_req_valid}, 32'd0);
      chk("R1 reset no response", {31'd0, l_rsp_valid | b_rsp_valid}, 32'd0);
      cpu_access(1'b0, 1'b0, 2'd0, 2'd2, 32'h0);
      chk("R1 reset read strobe", {31'd0, l_rsp_valid}, 32'd1);
      chk("R1 reset value", l_rsp_data, 32'h0);
   endtask

   task automatic t_index_rw;
      set_index(32'h5A5A_1234);
      cpu_access(1'b0, 1'b0, 2'd0, 2'd2, 32'h0);
      chk("R1 readback strobe", {31'd0, b_rsp_valid}, 32'd1);
      chk("R1 readback", l_rsp_data, 32'h5A5A_1234);
      set_index(32'hA5A5_EDCB);
      cpu_access(1'b0, 1'b0, 2'd0, 2'd2, 32'h0);
      chk("R1 readback 2", b_rsp_data, 32'hA5A5_EDCB);
   endtask

   task automatic t_closed_write;
      set_index(32'h0000_1234);
      cpu_access(1'b1, 1'b1, 2'd0, 2'd2, 32'hCAFE_F00D);
      chk("R2 ready kept", {31'd0, l_ready & b_ready}, 32'd1);
      for (int i = 0; i < 4; i++) begin
         chk("R2 no request", {31'd0, l_req_valid | b_req_valid}, 32'd0);
         chk("R2 no response", {31'd0, l_rsp_valid | b_rsp_valid}, 32'd0);
         @(negedge clk);
      end
   endtask

   task automatic t_closed_read;
      logic [31:0] ones [3];
      ones[0] = 32'h0000_00FF;
      ones[1] = 32'h0000_FFFF;
      ones[2] = 32'hFFFF_FFFF;
      for (int s = 0; s < 3; s++) begin
         cpu_access(1'b1, 1'b0, 2'd1, 2'(s), 32'h0);
         chk("R3 strobe", {31'd0, l_rsp_valid & b_rsp_valid}, 32'd1);
         chk("R3 value le", l_rsp_data, ones[s]);
         chk("R3 value be", b_rsp_data, ones[s]);
         chk("R3 no request", {31'd0, l_req_valid | b_req_valid}, 32'd0);
      end
   endtask

   task automatic check_issue(input string req, input logic we, input logic [31:0] exp_addr,
                              input logic [2:0] exp_size, input int stall);
      chk({req, " valid"}, {31'd0, l_req_valid & b_req_valid}, 32'd1);
      chk({req, " R11 busy"}, {31'd0, l_ready | b_ready}, 32'd0);
      chk({req, " we"}, {31'd0, l_req_we}, {31'd0, we});
      chk({req, " addr le"}, l_req_addr, exp_addr);
      chk({req, " addr be"}, b_req_addr, exp_addr);
      chk({req, " R8 size"}, {29'd0, l_req_size}, {29'd0, exp_size});
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         chk("R4 held valid", {31'd0, l_req_valid & b_req_valid}, 32'd1);
         chk("R4 held addr", l_req_addr, exp_addr);
      end
      cfg_req_ready = 1'b1;
      @(negedge clk);
      cfg_req_ready = 1'b0;
      chk("R4 dropped after handshake", {31'd0, l_req_valid | b_req_valid}, 32'd0);
   endtask

   task automatic fwd_write(input string req, input logic [1:0] lo, input logic [1:0] size,
                            input logic [31:0] wdata, input logic [31:0] exp_addr,
                            input logic [31:0] exp_le, input logic [31:0] exp_be,
                            input int stall);
      logic [2:0] es;
      es = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;
      cpu_access(1'b1, 1'b1, lo, size, wdata);
      chk({req, " R9 wdata le"}, l_req_wdata, exp_le);
      chk({req, " R10 wdata be"}, b_req_wdata, exp_be);
      check_issue(req, 1'b1, exp_addr, es, stall);
      chk("R11 ready after write", {31'd0, l_ready & b_ready}, 32'd1);
   endtask

   task automatic fwd_read(input string req, input logic [1:0] lo, input logic [1:0] size,
                           input logic [31:0] rsp, input logic [31:0] exp_addr,
                           input logic [31:0] exp_le, input logic [31:0] exp_be,
                           input int stall);
      logic [2:0] es;
      es = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;
      cpu_access(1'b1, 1'b0, lo, size, 32'h0);
      check_issue(req, 1'b0, exp_addr, es, stall);
      for (int i = 0; i < 2; i++) begin
         chk("R11 wait busy", {31'd0, l_ready | b_ready}, 32'd0);
         chk("R11 wait no strobe", {31'd0, l_rsp_valid | b_rsp_valid}, 32'd0);
         @(negedge clk);
      end
      cfg_rsp_valid = 1'b1;
      cfg_rsp_data  = rsp;
      @(negedge clk);
      cfg_rsp_valid = 1'b0;
      cfg_rsp_data  = 32'h0;
      chk("R11 strobe", {31'd0, l_rsp_valid & b_rsp_valid}, 32'd1);
      chk("R11 ready again", {31'd0, l_ready & b_ready}, 32'd1);
      chk({req, " R9 rdata le"}, l_rsp_data, exp_le);
      chk({req, " R10 rdata be"}, b_rsp_data, exp_be);
   endtask

   task automatic t_writes;
      set_index(32'h8000_1230);
      fwd_write("R5 byte", 2'd3, 2'd0, 32'hFFFF_FFAB, 32'h8000_1233, 32'h0000_00AB, 32'h0000_00AB, 0);
      fwd_write("R5 half", 2'd2, 2'd1, 32'hDEAD_1234, 32'h8000_1232, 32'h0000_1234, 32'h0000_3412, 1);
      fwd_write("R6 word", 2'd2, 2'd2, 32'h1122_3344, 32'h8000_1230, 32'h1122_3344, 32'h4433_2211, 3);
      set_index(32'h8000_1231);
      fwd_write("R6 word keep", 2'd2, 2'd2, 32'h0102_0304, 32'h8000_1231, 32'h0102_0304, 32'h0403_0201, 0);
      fwd_write("R5 half or", 2'd2, 2'd1, 32'h0000_BEEF, 32'h8000_1233, 32'h0000_BEEF, 32'h0000_EFBE, 2);
   endtask

   task automatic t_reads;
      set_index(32'h8000_1230);
      fwd_read("R7 byte", 2'd1, 2'd0, 32'hA1B2_C3D4, 32'h8000_1231, 32'h0000_00D4, 32'h0000_00D4, 0);
      fwd_read("R7 half", 2'd2, 2'd1, 32'hA1B2_C3D4, 32'h8000_1232, 32'h0000_C3D4, 32'h0000_D4C3, 2);
      fwd_read("R7 word", 2'd3, 2'd2, 32'hA1B2_C3D4, 32'h8000_1233, 32'hA1B2_C3D4, 32'hD4C3_B2A1, 1);
   endtask

   task automatic t_reclose;
      set_index(32'h7FFF_FFFF);
      cpu_access(1'b1, 1'b0, 2'd0, 2'd2, 32'h0);
      chk("R3 reclosed word", l_rsp_data, 32'hFFFF_FFFF);
      chk("R3 reclosed no request", {31'd0, l_req_valid | b_req_valid}, 32'd0);
      cpu_access(1'b1, 1'b1, 2'd0, 2'd1, 32'h1111_2222);
      chk("R2 reclosed drop", {31'd0, l_req_valid | b_req_valid}, 32'd0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_index_rw;
      t_closed_write;
      t_closed_read;
      t_writes;
      t_reads;
      t_reclose;
      repeat (2) @(negedge clk);
      finish_run;
   end

   initial begin
      #(8 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run;
   end

endmodule